// File: doc/BRIEF.md
# Packet Transmit Framer with PN9 Whitening

This block turns a byte stream taken from a transmit FIFO into a framed serial bit stream, one bit per clock while a packet is in flight. A one-cycle `start` pulse latches the packet configuration and begins the frame. The frame opens with a run of alternating-bit preamble bytes. It continues with a 16-bit sync word, which is sent twice when the doubling flag is set. The payload bytes follow, and an optional CRC-16 closes the frame. Every bit on `tx_bit` is marked by `tx_strb`.

When the FIFO has nothing ready by the time the minimum preamble has gone out, the framer keeps sending preamble bytes until data shows up. Whitening, when enabled, scrambles only the payload and CRC bits with a PN9 sequence. The CRC is always computed on the unscrambled payload. If the FIFO runs dry in the middle of the payload, the packet is cut short and a sticky error flag is raised.

Top module: `pkt_tx_framer`

## Requirements
- R1: After reset `tx_strb`, `busy`, `done`, `err` and `fifo_ready` are all low.
- R2: The preamble is sent MSB first as alternating bits beginning with 1 (each byte 0xAA). Its minimum length follows `pre_code` 0..7 → 2, 3, 4, 6, 8, 12, 16, 24 bytes.
- R3: The preamble ends only at a byte boundary where the minimum count has been met and `fifo_valid` is high; otherwise another whole preamble byte is sent.
- R4: The sync word follows the preamble with no gap, MSB first: 16 bits, or the same 16 bits twice (32 bits) when `sync_dbl` was set at start.
- R5: Exactly `pkt_len` payload bytes are sent, MSB first, each taken by one `fifo_ready && fifo_valid` transfer. With `pkt_len` = 0 no FIFO transfer takes place and no payload bits are sent.
- R6: With whitening on, each payload and CRC bit is XORed with `s[0]` of a 9-bit register `s`. The register is seeded to 0x1FF at start and steps once per whitened bit as `s <= {s[0]^s[5], s[8:1]}`. Preamble and sync bits are never whitened.
- R7: With CRC enabled, 16 CRC bits follow the payload MSB first. The CRC starts at 0xFFFF and, for each unwhitened payload bit b (MSB first), is updated as `crc = {crc[14:0],0} ^ ((crc[15]^b) ? 0x8005 : 0)`. With CRC disabled nothing follows the payload.
- R8: `tx_strb` is high in every cycle of the frame and in no other cycle. `done` pulses for exactly one cycle, in the cycle right after the last bit of a completed frame.
- R9: If `fifo_valid` is low when a payload byte is needed, the frame stops at once without a `done` pulse, and `err` goes high. `err` stays high until the next accepted `start`.
- R10: A `start` pulse while `busy` is ignored, and configuration inputs changed during a frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| pkt_len | input | LEN_W | Payload length in bytes |
| pre_code | input | 3 | Minimum preamble length code |
| sync_word | input | SYNC_W | Sync word value |
| sync_dbl | input | 1 | Send the sync word twice |
| white_en | input | 1 | Enable PN9 whitening of payload and CRC |
| crc_en | input | 1 | Append CRC-16 |
| fifo_data | input | 8 | FIFO head byte |
| fifo_valid | input | 1 | FIFO head byte present |
| fifo_ready | output | 1 | Framer takes the head byte this cycle |
| tx_bit | output | 1 | Serial output bit |
| tx_strb | output | 1 | `tx_bit` carries a frame bit |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after a completed frame |
| err | output | 1 | Sticky FIFO underflow flag |

## Verification
A wrong bit counter or state shows up as a frame whose length differs from the one computed from the configuration, and this is visible at the first misplaced byte boundary. A slip in the PN9 or CRC registers corrupts the bit stream from the first whitened bit, or at the latest in the trailing 16 CRC bits, so each frame is compared bit by bit against a model built only from the requirements. Preamble extension and underflow abort are both tied to byte boundaries. Checking the exact captured bit count therefore pins a wrong decision to within eight cycles.

// File: rtl/pktx_pkg.sv
package pktx_pkg;

  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SYNC,
    ST_DATA,
    ST_CRC
  } txst_e;

  // code 0..7 -> 2,3,4,6,8,12,16,24 bytes: (2 or 3) shifted by code[2:1]
  function automatic logic [PRE_W-1:0] pre_min_bytes(input logic [2:0] code);
    logic [PRE_W-1:0] base;
    base = code[0] ? PRE_W'(3) : PRE_W'(2);
    return base << code[2:1];
  endfunction

endpackage

// File: rtl/pktx_pn9.sv
module pktx_pn9 #(
  parameter int           PN_W    = 9,
  parameter int           PN_TAP  = 5,
  parameter logic [8:0]   PN_SEED = 9'h1FF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic adv,
  output logic bit_o
);

  logic [PN_W-1:0] s_q, s_d;

  always_comb begin
    s_d = s_q;
    if (init)
      s_d = PN_SEED[PN_W-1:0];
    else if (adv)
      s_d = {s_q[0] ^ s_q[PN_TAP], s_q[PN_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      s_q <= PN_SEED[PN_W-1:0];
    else
      s_q <= s_d;
  end

  assign bit_o = s_q[0];

  AST_PN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !init |-> (s_q != '0)); // R6

endmodule

// File: rtl/pktx_crc16.sv
module pktx_crc16 #(
  parameter int          CRC_W    = 16,
  parameter logic [15:0] CRC_POLY = 16'h8005,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic step,
  input  logic din,
  input  logic shift,
  output logic msb
);

  logic [CRC_W-1:0] c_q, c_d;

  always_comb begin
    c_d = c_q;
    if (init)
      c_d = CRC_INIT[CRC_W-1:0];
    else if (step)
      c_d = {c_q[CRC_W-2:0], 1'b0} ^ ((c_q[CRC_W-1] ^ din) ? CRC_POLY[CRC_W-1:0] : '0);
    else if (shift)
      c_d = {c_q[CRC_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      c_q <= CRC_INIT[CRC_W-1:0];
    else
      c_q <= c_d;
  end

  assign msb = c_q[CRC_W-1];

  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(init || step || shift) |=> $stable(c_q)); // R7

endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
  import pktx_pkg::*;
#(
  parameter int          LEN_W    = 8,
  parameter int          SYNC_W   = 16,
  parameter int          CRC_W    = 16,
  parameter logic [15:0] CRC_POLY = 16'h8005,
  parameter logic [15:0] CRC_INIT = 16'hFFFF,
  parameter int          PN_W     = 9,
  parameter int          PN_TAP   = 5,
  parameter logic [8:0]  PN_SEED  = 9'h1FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [2:0]        pre_code,
  input  logic [SYNC_W-1:0] sync_word,
  input  logic              sync_dbl,
  input  logic              white_en,
  input  logic              crc_en,
  input  logic [7:0]        fifo_data,
  input  logic              fifo_valid,
  output logic              fifo_ready,
  output logic              tx_bit,
  output logic              tx_strb,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int SH_W  = 2 * SYNC_W;
  localparam int CNT_W = $clog2(SH_W);
  localparam int BIT_W = $clog2(BYTE_W);

  txst_e             st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PRE_W-1:0]  pre_bytes_q, pre_bytes_d;
  logic [PRE_W-1:0]  pre_min_q, pre_min_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic              dbl_q, dbl_d;
  logic              white_q, white_d;
  logic              crc_en_q, crc_en_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic              crc_init, crc_step, crc_shift, crc_msb;
  logic              pn_init, pn_adv, pn_bit;
  logic              byte_end, sync_end, crc_end;
  logic [PRE_W-1:0]  pre_inc;

  assign byte_end = (cnt_q[BIT_W-1:0] == '1);
  assign sync_end = (cnt_q == (dbl_q ? CNT_W'(SH_W - 1) : CNT_W'(SYNC_W - 1)));
  assign crc_end  = (cnt_q == CNT_W'(CRC_W - 1));
  assign pre_inc  = (pre_bytes_q == '1) ? pre_bytes_q : pre_bytes_q + PRE_W'(1);

  pktx_pn9 #(
    .PN_W    (PN_W),
    .PN_TAP  (PN_TAP),
    .PN_SEED (PN_SEED)
  ) u_pn (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (pn_init),
    .adv   (pn_adv),
    .bit_o (pn_bit)
  );

  pktx_crc16 #(
    .CRC_W    (CRC_W),
    .CRC_POLY (CRC_POLY),
    .CRC_INIT (CRC_INIT)
  ) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (crc_init),
    .step  (crc_step),
    .din   (sh_q[SH_W-1]),
    .shift (crc_shift),
    .msb   (crc_msb)
  );

  // next-state process
  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    pre_bytes_d = pre_bytes_q;
    pre_min_d   = pre_min_q;
    len_d       = len_q;
    left_d      = left_q;
    sh_d        = sh_q;
    dbl_d       = dbl_q;
    white_d     = white_q;
    crc_en_d    = crc_en_q;
    done_d      = 1'b0;
    err_d       = err_q;
    fifo_ready  = 1'b0;
    crc_init    = 1'b0;
    crc_step    = 1'b0;
    crc_shift   = 1'b0;
    pn_init     = 1'b0;
    pn_adv      = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d        = ST_PRE;
          cnt_d       = '0;
          pre_bytes_d = '0;
          pre_min_d   = pre_min_bytes(pre_code);
          len_d       = pkt_len;
          dbl_d       = sync_dbl;
          white_d     = white_en;
          crc_en_d    = crc_en;
          err_d       = 1'b0;
          crc_init    = 1'b1;
          pn_init     = 1'b1;
          sh_d        = sync_dbl ? {sync_word, sync_word} : {sync_word, {SYNC_W{1'b0}}};
        end
      end

      ST_PRE: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (byte_end) begin
          cnt_d       = '0;
          pre_bytes_d = pre_inc;
          if ((pre_inc >= pre_min_q) && fifo_valid)
            st_d = ST_SYNC;
        end
      end

      ST_SYNC: begin
        cnt_d = cnt_q + CNT_W'(1);
        sh_d  = sh_q << 1;
        if (sync_end) begin
          cnt_d = '0;
          if (len_q == '0) begin
            if (crc_en_q) begin
              st_d = ST_CRC;
            end else begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end
          end else begin
            fifo_ready = 1'b1;
            if (fifo_valid) begin
              st_d   = ST_DATA;
              sh_d   = {fifo_data, {(SH_W-BYTE_W){1'b0}}};
              left_d = len_q - LEN_W'(1);
            end else begin
              st_d  = ST_IDLE;
              err_d = 1'b1;
            end
          end
        end
      end

      ST_DATA: begin
        cnt_d    = cnt_q + CNT_W'(1);
        sh_d     = sh_q << 1;
        crc_step = 1'b1;
        pn_adv   = 1'b1;
        if (byte_end) begin
          cnt_d = '0;
          if (left_q == '0) begin
            if (crc_en_q) begin
              st_d = ST_CRC;
            end else begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end
          end else begin
            fifo_ready = 1'b1;
            if (fifo_valid) begin
              sh_d   = {fifo_data, {(SH_W-BYTE_W){1'b0}}};
              left_d = left_q - LEN_W'(1);
            end else begin
              st_d  = ST_IDLE;
              err_d = 1'b1;
            end
          end
        end
      end

      ST_CRC: begin
        cnt_d     = cnt_q + CNT_W'(1);
        crc_shift = 1'b1;
        pn_adv    = 1'b1;
        if (crc_end) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end

      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      pre_bytes_q <= '0;
      pre_min_q   <= '0;
      len_q       <= '0;
      left_q      <= '0;
      sh_q        <= '0;
      dbl_q       <= 1'b0;
      white_q     <= 1'b0;
      crc_en_q    <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      pre_bytes_q <= pre_bytes_d;
      pre_min_q   <= pre_min_d;
      len_q       <= len_d;
      left_q      <= left_d;
      sh_q        <= sh_d;
      dbl_q       <= dbl_d;
      white_q     <= white_d;
      crc_en_q    <= crc_en_d;
      done_q      <= done_d;
      err_q       <= err_d;
    end
  end

  // serial output selection
  always_comb begin
    unique case (st_q)
      ST_PRE:  tx_bit = ~cnt_q[0];
      ST_SYNC: tx_bit = sh_q[SH_W-1];
      ST_DATA: tx_bit = sh_q[SH_W-1] ^ (white_q & pn_bit);
      ST_CRC:  tx_bit = crc_msb ^ (white_q & pn_bit);
      default: tx_bit = 1'b0;
    endcase
  end

  assign tx_strb = (st_q != ST_IDLE);
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign err     = err_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_POP_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> (st_q == ST_SYNC || st_q == ST_DATA)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(st_q == ST_IDLE && start)) |=> err); // R9
  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !done); // R9
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> ($stable(len_q) && $stable(pre_min_q))); // R10

endmodule

// File: tb/sim_pkt_tx_framer.sv
`timescale 1ns/1ps
module sim_pkt_tx_framer;

  localparam logic [15:0] SYNC = 16'hD391;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [7:0] pkt_len;
  logic [2:0] pre_code;
  logic [15:0] sync_word;
  logic       sync_dbl, white_en, crc_en;
  logic [7:0] fifo_data;
  logic       fifo_valid, fifo_ready;
  logic       tx_bit, tx_strb, busy, done, err;

  pkt_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt_len(pkt_len),
    .pre_code(pre_code), .sync_word(sync_word), .sync_dbl(sync_dbl),
    .white_en(white_en), .crc_en(crc_en), .fifo_data(fifo_data),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .tx_bit(tx_bit),
    .tx_strb(tx_strb), .busy(busy), .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int tests, fails;

  // FIFO model
  logic [7:0] pay [0:63];
  int   pay_n;
  int   rd_idx;
  logic gate, fifo_clr;
  assign fifo_valid = gate && (rd_idx < pay_n);
  assign fifo_data  = pay[rd_idx[5:0]];
  always @(posedge clk) begin
    if (fifo_clr) rd_idx <= 0;
    else if (fifo_ready && fifo_valid) rd_idx <= rd_idx + 1;
  end

  bit exp_bits [0:1023];
  int exp_n;

  // fields: code[21:19] dbl[18] white[17] crc[16] len[15:8] seed[7:0]
  localparam logic [21:0] VEC [7] = '{
    {3'd0, 1'b0, 1'b0, 1'b1, 8'd3, 8'h11},
    {3'd1, 1'b1, 1'b0, 1'b1, 8'd5, 8'hA5},
    {3'd3, 1'b0, 1'b1, 1'b1, 8'd4, 8'h00},
    {3'd5, 1'b1, 1'b1, 1'b0, 8'd2, 8'hFF},
    {3'd7, 1'b0, 1'b1, 1'b1, 8'd8, 8'h3C},
    {3'd2, 1'b0, 1'b0, 1'b0, 8'd1, 8'h80},
    {3'd6, 1'b0, 1'b0, 1'b1, 8'd6, 8'h5A}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  // expected frame built from the requirements; also sets DUT config
  task automatic build(input logic [2:0] code, input bit dbl, input bit wh,
                       input bit ce, input int len, input logic [7:0] seed,
                       input int extra);
    int np;
    logic [8:0] s;
    logic [15:0] c;
    logic [7:0] b;
    bit pb;
    exp_n = 0;
    np = ((2 + int'(code[0])) << code[2:1]) + extra;           // R2
    for (int i = 0; i < np * 8; i++) begin exp_bits[exp_n] = (i % 2 == 0); exp_n++; end
    for (int r = 0; r < (dbl ? 2 : 1); r++)                      // R4
      for (int i = 15; i >= 0; i--) begin exp_bits[exp_n] = SYNC[i]; exp_n++; end
    s = 9'h1FF;
    c = 16'hFFFF;
    for (int k = 0; k < len; k++) begin                          // R5
      b = seed + 8'(k * 37);
      pay[k] = b;
      for (int i = 7; i >= 0; i--) begin
        pb = b[i];
        exp_bits[exp_n] = pb ^ (wh & s[0]);                      // R6
        exp_n++;
        s = {s[0] ^ s[5], s[8:1]};
        c = (c[15] ^ pb) ? ({c[14:0], 1'b0} ^ 16'h8005) : {c[14:0], 1'b0};
      end
    end
    pay_n = len;
    if (ce)                                                      // R7
      for (int i = 15; i >= 0; i--) begin
        exp_bits[exp_n] = c[i] ^ (wh & s[0]);
        exp_n++;
        s = {s[0] ^ s[5], s[8:1]};
      end
    pre_code = code; sync_dbl = dbl; white_en = wh; crc_en = ce;
    pkt_len = 8'(len); sync_word = SYNC;
  endtask

  task automatic run(input int gate_at, input int bump_at,
                     output int got_n, output int mism, output int dones);
    int idle;
    got_n = 0; mism = 0; dones = 0; idle = 0;
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    gate = (gate_at < 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 3000 && idle < 4; cyc++) begin
      if (tx_strb) begin
        idle = 0;
        if (got_n < exp_n) begin
          if (tx_bit !== exp_bits[got_n]) mism++;
        end else mism++;
        if (got_n == gate_at) gate = 1'b1;
        if (got_n == bump_at) begin
          start = 1'b1; pkt_len = 8'd9; pre_code = 3'd7; sync_dbl = 1'b1;
        end
        got_n++;
      end else idle++;
      if (done) dones++;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R8 watchdog expired: got %0d expected %0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int got, mm, dn, pre_b;
    tests = 0; fails = 0;
    rst_n = 1'b0; start = 1'b0; fifo_clr = 1'b1; gate = 1'b0; pay_n = 0;
    pkt_len = '0; pre_code = '0; sync_word = SYNC; sync_dbl = 1'b0;
    white_en = 1'b0; crc_en = 1'b0;
    for (int i = 0; i < 64; i++) pay[i] = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!tx_strb && !busy, "R1", "strobe/busy in reset", int'(tx_strb), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !err && !fifo_ready && !tx_strb && !busy, "R1", "outputs after reset",
        int'({done, err, fifo_ready, tx_strb, busy}), 0);

    // table of vectors walked by one loop
    foreach (VEC[v]) begin
      build(VEC[v][21:19], VEC[v][18], VEC[v][17], VEC[v][16],
            int'(VEC[v][15:8]), VEC[v][7:0], 0);
      run(-1, -1, got, mm, dn);
      chk(got == exp_n, "R2/R4/R7", $sformatf("vec %0d frame length", v), got, exp_n);
      chk(mm == 0, "R2/R4/R6/R7", $sformatf("vec %0d bit mismatches", v), mm, 0);
      chk(dn == 1 && !err, "R8", $sformatf("vec %0d done pulses", v), dn, 1);
      chk(rd_idx == int'(VEC[v][15:8]), "R5", $sformatf("vec %0d fifo pops", v),
          rd_idx, int'(VEC[v][15:8]));
    end

    // R3 preamble extension: data appears mid-byte after the minimum (4 bytes)
    build(3'd2, 1'b0, 1'b1, 1'b1, 3, 8'h42, 1);
    run(8 * 4 + 3, -1, got, mm, dn);
    chk(got == exp_n, "R3", "extended frame length", got, exp_n);
    chk(mm == 0, "R3", "extended frame bits", mm, 0);

    // R10 start while busy, with config changed mid-frame
    build(3'd0, 1'b0, 1'b0, 1'b1, 3, 8'h77, 0);
    run(-1, 20, got, mm, dn);
    chk(got == exp_n && mm == 0, "R10", "frame after ignored start", got, exp_n);
    chk(dn == 1, "R10", "single done after ignored start", dn, 1);

    // R5 zero-length payload: no pop, CRC of nothing
    build(3'd1, 1'b0, 1'b1, 1'b1, 0, 8'h00, 0);
    pay[0] = 8'hC3; pay_n = 1;
    run(-1, -1, got, mm, dn);
    chk(got == exp_n && mm == 0, "R5", "zero-length frame", got, exp_n);
    chk(rd_idx == 0, "R5", "zero-length pops", rd_idx, 0);

    // R9 underflow: 4 bytes requested, 2 supplied
    build(3'd0, 1'b0, 1'b0, 1'b1, 4, 8'h19, 0);
    pay_n = 2;
    pre_b = 2;
    run(-1, -1, got, mm, dn);
    chk(got == pre_b * 8 + 16 + 16, "R9", "bits before abort", got, pre_b * 8 + 32);
    chk(mm == 0, "R9", "bits before abort match", mm, 0);
    chk(dn == 0, "R9", "no done on abort", dn, 0);
    chk(err == 1'b1, "R9", "err after abort", int'(err), 1);
    repeat (10) @(negedge clk);
    chk(err == 1'b1 && !tx_strb, "R9", "err sticky while idle", int'(err), 1);

    // R9 recovery: next start clears err
    build(3'd0, 1'b0, 1'b1, 1'b1, 2, 8'hE0, 0);
    run(-1, -1, got, mm, dn);
    chk(err == 1'b0, "R9", "err cleared by start", int'(err), 0);
    chk(got == exp_n && mm == 0 && dn == 1, "R8", "frame after recovery", mm, 0);

    summary();
    $finish;
  end

endmodule